// File: doc/BRIEF.md
# GPIO Bank Register File with Mask-Selected Line Configuration

This block holds the control state of one bank of 32 general-purpose I/O lines behind a small word-addressed bus. The bus has an address, a write strobe, write data and read data. Every line owns a configuration word. The word carries a function select, a direction bit, pad-control bits and an event selector. The configuration words have no addresses of their own. Software first loads a line-selection mask, and then a single configuration offset reaches every line whose mask bit is set. One write can therefore configure many lines at once.

The bank also keeps a 32-bit output data latch. That latch is changed through separate write-one-to-set and write-one-to-clear offsets and can be read back. The sampled levels of the input pins are also readable. Toward the pad wrapper the bank drives, for each line, the output data bit, the direction bit and the three-bit function select. Consecutive banks are placed 0x40 bytes apart, so the bank decodes a 6-bit byte offset.

Top module: `gpio_bank_regs`

## Requirements
- R1: After a clock edge with `rst_n` low, the mask, the output latch and every configuration word are 0. So `out_data`, `dir_out` and `func_out` are all 0, which makes every line a GPIO input.
- R2: Offset 0x00 is the line-selection mask. A write stores all 32 bits and a read returns them.
- R3: A write to offset 0x04 replaces, from the next cycle, the configuration word of every line whose mask bit is set. Lines whose mask bit is clear keep their words.
- R4: A read of offset 0x04 returns the configuration word of the lowest-numbered line whose mask bit is set. It returns 0 when the mask is 0.
- R5: Only bits 2:0, 8, 9, 10, 12, 13, 14, 15 and 26:24 of a configuration word are stored (mask 0x0700F707). All other bits ignore writes and read as 0.
- R6: A write to offset 0x10 sets to 1 each output bit whose data bit is 1. A write to 0x14 clears to 0 each output bit whose data bit is 1. Bits written as 0 keep their value.
- R7: Offset 0x18 reads the output latch, and the `out_data` port always equals that latch.
- R8: Offset 0x08 returns `pin_in` as it was sampled two clock edges earlier.
- R9: Offset 0x0C always reads 0. Writes to 0x08, 0x0C and 0x18 change no state.
- R10: `dir_out[i]` equals bit 8 of line i's configuration word, where 1 means output. `func_out[3*i+2:3*i]` equals bits 2:0 of that word, where 0 selects GPIO and 1 to 7 select peripheral functions.
- R11: Reads of offsets 0x10, 0x14, 0x1C to 0x3C or any offset not a multiple of 4 return 0. Writes to such offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 6 | Byte offset within the bank |
| bus_we | input | 1 | Write strobe for the current offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset, combinational |
| pin_in | input | 32 | Asynchronous input pin levels |
| out_data | output | 32 | Output data latch toward the pads |
| dir_out | output | 32 | Per-line direction, 1 = drive |
| func_out | output | 96 | Per-line 3-bit function select, line i at bits 3i+2:3i |

## Verification
The hardest case to reach is a configuration read where several mask bits are set and the selected lines hold different words. Only then does the lowest-line priority show, and only then would a wrong priority or an OR-merge of the words be caught. The stimulus first writes distinct words through single-line masks. It then widens the mask to cover lines holding different words and reads the configuration back. It also rereads after narrowing the mask to 0. A long pseudo-random phase mixes mask, configuration, set and clear traffic while the pins toggle every cycle. Every cycle is compared against a behavioural model.

// File: rtl/gpio_bank_pkg.sv
// Shared constants for the GPIO bank register file.
// Assumes 32-bit data words and a 6-bit byte offset (0x40 bank span).
package gpio_bank_pkg;
    localparam int WORD_W  = 32;
    localparam int FUNC_W  = 3;
    localparam int DIR_BIT = 8;

    // Word index (byte offset / 4) of each register in the bank.
    typedef enum logic [3:0] {
        IDX_LINE_SEL  = 4'h0,
        IDX_LINE_CFG  = 4'h1,
        IDX_PIN_LEVEL = 4'h2,
        IDX_LOCK_STAT = 4'h3,
        IDX_OUT_SET   = 4'h4,
        IDX_OUT_CLR   = 4'h5,
        IDX_OUT_LEVEL = 4'h6
    } reg_idx_e;

    // Configuration bits that are stored; all others read as zero.
    localparam logic [WORD_W-1:0] CFG_KEEP = 32'h0700_F707;
endpackage

// File: rtl/gpio_pin_sync.sv
// Two-stage synchronizer for asynchronous input pins.
// Assumes no reset is needed: the stages settle after two clocks.
module gpio_pin_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the pin levels through two flops.
    always_ff @(posedge clk) begin
        stage1_q <= async_in;
        stage2_q <= stage1_q;
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_cfg_array.sv
// Per-line configuration words, written through a line-selection mask.
// A write updates every selected line. A read returns the lowest selected line.
module gpio_cfg_array
    import gpio_bank_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int DW     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NLINES-1:0]        sel_mask,
    input  logic                     wr_en,
    input  logic [DW-1:0]            wr_word,
    output logic [DW-1:0]            rd_word,
    output logic [NLINES-1:0]        line_dir,
    output logic [NLINES*FUNC_W-1:0] line_func
);
    localparam logic [DW-1:0] KEEP = DW'(CFG_KEEP);

    logic [NLINES*DW-1:0] words_flat;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic [DW-1:0] word_q;

        // Hold this line's word; load it when the line is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (wr_en && sel_mask[i])
                word_q <= wr_word & KEEP;
        end

        assign words_flat[i*DW +: DW]         = word_q;
        assign line_dir[i]                    = word_q[DIR_BIT];
        assign line_func[i*FUNC_W +: FUNC_W]  = word_q[FUNC_W-1:0];
    end

    // Pick the word of the lowest-numbered selected line.
    always_comb begin
        rd_word = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (sel_mask[i])
                rd_word = words_flat[i*DW +: DW];
        end
    end
endmodule

// File: rtl/gpio_out_latch.sv
// Output data latch with write-one-to-set and write-one-to-clear updates.
// Assumes set and clear never arrive in the same cycle.
module gpio_out_latch #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] bits,
    output logic [WIDTH-1:0] level_q
);
    // Apply the set or clear pattern to the latch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= '0;
        else if (set_en)
            level_q <= level_q | bits;
        else if (clr_en)
            level_q <= level_q & ~bits;
    end
endmodule

// File: rtl/gpio_bank_regs.sv
// Register file for one GPIO bank: the mask, the mask-selected
// configuration words, the output latch and the synchronized pin levels.
// Assumes word-aligned accesses; misaligned offsets read 0 and drop writes.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int ADDR_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic [WORD_W-1:0]        bus_rdata,
    input  logic [NLINES-1:0]        pin_in,
    output logic [NLINES-1:0]        out_data,
    output logic [NLINES-1:0]        dir_out,
    output logic [NLINES*FUNC_W-1:0] func_out
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  word_idx;
    logic              aligned;
    logic              hit_sel, hit_cfg, hit_pin, hit_set, hit_clr, hit_out;
    logic [NLINES-1:0] mask_q;
    logic [WORD_W-1:0] cfg_rd;
    logic [NLINES-1:0] pin_sync;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);

    // Decode which register the current offset reaches.
    always_comb begin
        hit_sel = aligned && (word_idx == IDX_W'(IDX_LINE_SEL));
        hit_cfg = aligned && (word_idx == IDX_W'(IDX_LINE_CFG));
        hit_pin = aligned && (word_idx == IDX_W'(IDX_PIN_LEVEL));
        hit_set = aligned && (word_idx == IDX_W'(IDX_OUT_SET));
        hit_clr = aligned && (word_idx == IDX_W'(IDX_OUT_CLR));
        hit_out = aligned && (word_idx == IDX_W'(IDX_OUT_LEVEL));
    end

    // Keep the line-selection mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (bus_we && hit_sel)
            mask_q <= bus_wdata[NLINES-1:0];
    end

    gpio_cfg_array #(
        .NLINES (NLINES),
        .DW     (WORD_W)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_mask  (mask_q),
        .wr_en     (bus_we && hit_cfg),
        .wr_word   (bus_wdata),
        .rd_word   (cfg_rd),
        .line_dir  (dir_out),
        .line_func (func_out)
    );

    gpio_out_latch #(
        .WIDTH (NLINES)
    ) i_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (bus_we && hit_set),
        .clr_en  (bus_we && hit_clr),
        .bits    (bus_wdata[NLINES-1:0]),
        .level_q (out_data)
    );

    gpio_pin_sync #(
        .WIDTH (NLINES)
    ) i_sync (
        .clk      (clk),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    // Select the read data for the current offset.
    always_comb begin
        bus_rdata = '0;
        if (hit_sel)      bus_rdata = WORD_W'(mask_q);
        else if (hit_cfg) bus_rdata = cfg_rd;
        else if (hit_pin) bus_rdata = WORD_W'(pin_sync);
        else if (hit_out) bus_rdata = WORD_W'(out_data);
    end
endmodule

// File: rtl/gpio_bank_regs_chk.sv
// Property checker for gpio_bank_regs, bound to every instance.
// Assumes the mask register is reachable as mask_q inside the top.
module gpio_bank_regs_chk
    import gpio_bank_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int ADDR_W = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_we,
    input logic [WORD_W-1:0]        bus_wdata,
    input logic [WORD_W-1:0]        bus_rdata,
    input logic [NLINES-1:0]        pin_in,
    input logic [NLINES-1:0]        out_data,
    input logic [NLINES-1:0]        dir_out,
    input logic [NLINES*FUNC_W-1:0] func_out,
    input logic [NLINES-1:0]        mask_q
);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(6'h04);
    localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(6'h08);
    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(6'h0C);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(6'h10);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(6'h14);

    logic set_wr, clr_wr, cfg_wr;
    assign set_wr = bus_we && (bus_addr == A_SET);
    assign clr_wr = bus_we && (bus_addr == A_CLR);
    assign cfg_wr = bus_we && (bus_addr == A_CFG);

    a_r1_reset_state: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |->
            (out_data == '0 && dir_out == '0 && func_out == '0 && mask_q == '0));

    a_r3_unselected_keep: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> ((dir_out & ~$past(mask_q)) == ($past(dir_out) & ~$past(mask_q))));

    a_r3_selected_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> ((dir_out & $past(mask_q)) ==
                    ({NLINES{$past(bus_wdata[DIR_BIT])}} & $past(mask_q))));

    a_r5_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CFG) |-> ((bus_rdata & ~CFG_KEEP) == '0));

    a_r6_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> (out_data == ($past(out_data) | $past(bus_wdata[NLINES-1:0]))));

    a_r6_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (out_data == ($past(out_data) & ~$past(bus_wdata[NLINES-1:0]))));

    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_wr && !clr_wr) |=> $stable(out_data));

    a_r8_pin_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_PIN && $past(rst_n, 2)) |->
            (bus_rdata == WORD_W'($past(pin_in, 2))));

    a_r9_lock_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_LOCK) |-> (bus_rdata == '0));
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
    .NLINES (NLINES),
    .ADDR_W (ADDR_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .out_data  (out_data),
    .dir_out   (dir_out),
    .func_out  (func_out),
    .mask_q    (mask_q)
);

// File: tb/test_gpio_bank_regs.sv
`timescale 1ns/1ps
module test_gpio_bank_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] out_data;
    logic [31:0] dir_out;
    logic [95:0] func_out;

    gpio_bank_regs i_gpio_bank_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .out_data  (out_data),
        .dir_out   (dir_out),
        .func_out  (func_out)
    );

    always #2.5 clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    bit started = 0;
    bit was_reset = 0;
    logic [31:0] lf = 32'h1357_9BDF;

    // Behavioural reference state.
    logic [31:0] m_mask, m_out, m_s1, m_s2;
    logic [31:0] m_cfg [32];

    always @(posedge clk) begin
        was_reset = !rst_n;
        started = 1;
        if (!rst_n) begin
            m_mask = 0;
            m_out  = 0;
            foreach (m_cfg[i]) m_cfg[i] = 0;
        end else if (bus_we && bus_addr[1:0] == 2'b00) begin
            if (bus_addr == 6'h00) m_mask = bus_wdata;
            if (bus_addr == 6'h04)
                foreach (m_cfg[i]) if (m_mask[i]) m_cfg[i] = bus_wdata & 32'h0700_F707;
            if (bus_addr == 6'h10) m_out = m_out | bus_wdata;
            if (bus_addr == 6'h14) m_out = m_out & ~bus_wdata;
        end
        m_s2 = m_s1;
        m_s1 = pin_in;
    end

    function automatic logic [31:0] m_read(input logic [5:0] a);
        logic [31:0] r = 0;
        case (a)
            6'h00: r = m_mask;
            6'h04: for (int i = 31; i >= 0; i--) if (m_mask[i]) r = m_cfg[i];
            6'h08: r = m_s2;
            6'h18: r = m_out;
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic string tag_for(input logic [5:0] a);
        case (a)
            6'h00: return "R2 mask";
            6'h04: return "R4 R5 cfg read";
            6'h08: return "R8 pin level";
            6'h0C: return "R9 lock";
            6'h18: return "R7 out readback";
            default: return "R11 other offset";
        endcase
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [31:0] e_dir;
        logic [95:0] e_func;
        if (!started) return;
        for (int i = 0; i < 32; i++) begin
            e_dir[i] = m_cfg[i][8];
            e_func[i*3 +: 3] = m_cfg[i][2:0];
        end
        if (was_reset) begin
            chk("R1 reset outputs", {out_data, dir_out, func_out[31:0]}, 96'h0);
            chk("R1 reset mask read", bus_rdata, 32'h0);
        end else begin
            chk(tag_for(bus_addr), bus_rdata, m_read(bus_addr));
            chk("R6 R7 out_data", out_data, m_out);
            chk("R3 R10 dir_out", dir_out, e_dir);
            chk("R3 R10 func_out", func_out, e_func);
        end
    endtask

    task automatic op(input logic [5:0] a, input logic w, input logic [31:0] d);
        @(negedge clk);
        compare_all();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        bus_addr  = a;
        bus_we    = w;
        bus_wdata = d;
        pin_in    = lf ^ {lf[15:0], lf[31:16]};
    endtask

    task automatic finish_run();
        if (finished) return;
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) op(6'h00, 0, 0);
        rst_n = 1'b1;
        op(6'h00, 0, 0);
        // R2 and R5: two lines, all bits written, only kept bits stored
        op(6'h00, 1, 32'h0000_0005);
        op(6'h04, 1, 32'hFFFF_FFFF);
        op(6'h04, 0, 0);
        // R3: narrow the mask to line 2 and write a distinct word
        op(6'h00, 1, 32'h0000_0004);
        op(6'h04, 1, 32'h0000_0102);
        op(6'h04, 0, 0);
        // R4: wide mask -> lowest selected line wins
        op(6'h00, 1, 32'h0000_0005);
        op(6'h04, 0, 0);
        op(6'h00, 1, 32'h0000_0004);
        op(6'h04, 0, 0);
        op(6'h00, 1, 32'h0000_0000);
        op(6'h04, 0, 0);
        op(6'h04, 1, 32'h0000_0107);
        op(6'h04, 0, 0);
        op(6'h00, 1, 32'h8000_0000);
        op(6'h04, 1, 32'h0300_0105);
        op(6'h04, 0, 0);
        op(6'h00, 1, 32'hFFFF_FFFF);
        op(6'h00, 0, 0);
        op(6'h04, 1, 32'h0000_0003);
        op(6'h04, 0, 0);
        // R6 and R7: set and clear patterns
        op(6'h10, 1, 32'hA5A5_00FF);
        op(6'h18, 0, 0);
        op(6'h14, 1, 32'h0000_000F);
        op(6'h18, 0, 0);
        op(6'h10, 1, 32'h0000_0000);
        op(6'h14, 1, 32'h0000_0000);
        op(6'h10, 0, 0);
        // R9: writes to read-only offsets
        op(6'h08, 1, 32'hFFFF_FFFF);
        op(6'h0C, 1, 32'hFFFF_FFFF);
        op(6'h18, 1, 32'hFFFF_FFFF);
        op(6'h0C, 0, 0);
        op(6'h18, 0, 0);
        // R8: pin levels while pins change each cycle
        repeat (8) op(6'h08, 0, 0);
        // R11: unmapped and misaligned offsets
        op(6'h1C, 1, 32'hFFFF_FFFF);
        op(6'h3C, 1, 32'hFFFF_FFFF);
        op(6'h01, 1, 32'hFFFF_FFFF);
        op(6'h11, 1, 32'hFFFF_FFFF);
        op(6'h06, 0, 0);
        op(6'h20, 0, 0);
        op(6'h14, 0, 0);
        op(6'h04, 0, 0);
        op(6'h18, 0, 0);
        // Mixed pseudo-random traffic
        for (int n = 0; n < 600; n++) begin
            logic [5:0] a;
            logic [31:0] d;
            a = {1'b0, lf[2:0], 2'b00};
            if (lf[9:7] == 3'b000) a = a | 6'h01;
            d = lf[4] ? (32'h1 << lf[12:8]) : (lf ^ 32'h5A5A_C3C3);
            op(a, lf[5] | lf[6], d);
        end
        op(6'h00, 0, 0);
        op(6'h00, 0, 0);
        finish_run();
    end
endmodule